// File: doc/BRIEF.md
# Privilege-Mode Banked Register File

This block holds the sixteen 32-bit general registers of a processor core together with the shadow copies that belong to each privilege mode. Two combinational read ports and one clocked write port address the registers by logical number, so the datapath never sees which physical copy it is using. A mode-change strobe with a requested 5-bit mode code causes a swap on the next clock edge. The live copies of the banked registers are saved into the outgoing mode's shadow slots, and the incoming mode's copies take their place.

Stack pointer (R13), link register (R14) and the saved status word are banked for every privileged mode. Entering or leaving the fast-interrupt mode also exchanges R8 to R12. User and system mode share one unbanked set. The saved status word has its own write port and is always visible on an output.

Top module: `bankedRegFile`

## Requirements
- R1: While reset (rstN low) is asserted, every general register, every shadow slot and every saved status copy is cleared to zero, and the mode becomes system (5'b11111). After reset the live saved status reads zero, and registers restored by any later bank change read zero until they are written.
- R2: A change strobe loads the requested code into the current mode on the next edge. The codes are user 10000, fast-interrupt 10001, interrupt 10010, supervisor 10011, abort 10111, undefined 11011 and system 11111. Any other code selects the unbanked set.
- R3: A change request whose code equals the current mode alters no register and no saved status value.
- R4: User, system and unrecognised codes share one bank. Moving between them keeps R13, R14 and the saved status word unchanged.
- R5: When the outgoing and incoming banks differ, R13 and R14 are saved to the outgoing bank and reloaded from the incoming bank. Each bank keeps its values across any sequence of other modes.
- R6: When either side of a bank change is fast-interrupt, R8 to R12 are saved to the side being left (fast-interrupt copy or common copy) and restored from the other side.
- R7: A bank change that involves no fast-interrupt side leaves R8 to R12 untouched. R0 to R7 and R15 are never banked.
- R8: The saved status word is saved to the outgoing bank and reloaded from the incoming bank on every bank change. A status write lands in the live word on the next edge.
- R9: A register or status write in the same cycle as a bank change updates the incoming mode's copy, and the outgoing bank keeps its pre-write value.
- R10: Read ports are combinational from the live registers. A write is visible from the edge on which it is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| modeChg | input | 1 | Mode change strobe |
| modeReq | input | 5 | Requested mode code |
| curMode | output | 5 | Current mode code |
| rdAddrA | input | 4 | Read port A register number |
| rdDataA | output | 32 | Read port A data |
| rdAddrB | input | 4 | Read port B register number |
| rdDataB | output | 32 | Read port B data |
| wrEn | input | 1 | Register write enable |
| wrAddr | input | 4 | Register write number |
| wrData | input | 32 | Register write data |
| spsrWrEn | input | 1 | Saved status write enable |
| spsrWrData | input | 32 | Saved status write data |
| spsrOut | output | 32 | Live saved status word |

## Verification
The bench targets round trips through several modes, such as user to fast-interrupt to interrupt and back to user. A design that saved to the wrong bank, or that failed to exchange R8 to R12, would return stale or foreign values on those trips. It also hits same-mode requests and user/system moves, where a design that swapped anyway would lose the live values. Writes issued in the same cycle as a bank change are included. A design that let the outgoing copy win would read back the restored value instead of the written one. Unrecognised mode codes are used as well, and they must behave as the unbanked set rather than corrupting a privileged bank.

// File: rtl/bank_pkg.sv
package bank_pkg;
  localparam int NUM_BANKS = 6;
  localparam int BANK_W    = 3;
  localparam int HI_FIRST  = 8;
  localparam int HI_COUNT  = 5;
  localparam int SP_IDX    = 13;
  localparam int LR_IDX    = 14;

  localparam logic [4:0] MODE_USR = 5'b10000;
  localparam logic [4:0] MODE_FIQ = 5'b10001;
  localparam logic [4:0] MODE_IRQ = 5'b10010;
  localparam logic [4:0] MODE_SVC = 5'b10011;
  localparam logic [4:0] MODE_ABT = 5'b10111;
  localparam logic [4:0] MODE_UND = 5'b11011;
  localparam logic [4:0] MODE_SYS = 5'b11111;

  typedef enum logic [BANK_W-1:0] {
    BANK_COMMON = 3'd0,
    BANK_FAST   = 3'd1,
    BANK_INT    = 3'd2,
    BANK_SUPV   = 3'd3,
    BANK_ABORT  = 3'd4,
    BANK_UNDEF  = 3'd5
  } bankSel_e;

  typedef struct packed {
    logic     swap;
    logic     swapHigh;
    bankSel_e oldBank;
    bankSel_e newBank;
    logic     oldHiSide;
    logic     newHiSide;
  } swapCtrl_t;

  function automatic bankSel_e modeToBank(input logic [4:0] m);
    case (m)
      MODE_FIQ: return BANK_FAST;
      MODE_IRQ: return BANK_INT;
      MODE_SVC: return BANK_SUPV;
      MODE_ABT: return BANK_ABORT;
      MODE_UND: return BANK_UNDEF;
      default:  return BANK_COMMON;
    endcase
  endfunction
endpackage

// File: rtl/bankCtrl.sv
module bankCtrl
  import bank_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       modeChg,
  input  logic [4:0] modeReq,
  output logic [4:0] curMode,
  output swapCtrl_t  ctrl
);
  logic [4:0] modeQ;
  bankSel_e   curBank;
  bankSel_e   reqBank;
  logic       takeChange;

  assign curBank    = modeToBank(modeQ);
  assign reqBank    = modeToBank(modeReq);
  assign takeChange = modeChg && (modeReq != modeQ);

  always_comb begin
    ctrl.oldBank   = curBank;
    ctrl.newBank   = reqBank;
    ctrl.swap      = takeChange && (curBank != reqBank);
    ctrl.swapHigh  = ctrl.swap && ((curBank == BANK_FAST) || (reqBank == BANK_FAST));
    ctrl.oldHiSide = (curBank == BANK_FAST);
    ctrl.newHiSide = (reqBank == BANK_FAST);
  end

  always_ff @(posedge clk) begin
    if (!rstN)           modeQ <= MODE_SYS;
    else if (takeChange) modeQ <= modeReq;
  end

  assign curMode = modeQ;
endmodule

// File: rtl/bankData.sv
module bankData
  import bank_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int NUM_REGS = 16,
  localparam int ADDR_W  = $clog2(NUM_REGS)
)(
  input  logic              clk,
  input  logic              rstN,
  input  swapCtrl_t         ctrl,
  input  logic [ADDR_W-1:0] rdAddrA,
  output logic [DATA_W-1:0] rdDataA,
  input  logic [ADDR_W-1:0] rdAddrB,
  output logic [DATA_W-1:0] rdDataB,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic              spsrWrEn,
  input  logic [DATA_W-1:0] spsrWrData,
  output logic [DATA_W-1:0] spsrOut
);
  logic [DATA_W-1:0] gpr     [NUM_REGS];
  logic [DATA_W-1:0] spShadow[NUM_BANKS];
  logic [DATA_W-1:0] lrShadow[NUM_BANKS];
  logic [DATA_W-1:0] stShadow[NUM_BANKS];
  logic [DATA_W-1:0] hiShadow[2][HI_COUNT];
  logic [DATA_W-1:0] spsrLive;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_REGS; i++) gpr[i] <= '0;
      for (int b = 0; b < NUM_BANKS; b++) begin
        spShadow[b] <= '0;
        lrShadow[b] <= '0;
        stShadow[b] <= '0;
      end
      for (int s = 0; s < 2; s++)
        for (int k = 0; k < HI_COUNT; k++) hiShadow[s][k] <= '0;
      spsrLive <= '0;
    end else begin
      if (ctrl.swap) begin
        spShadow[ctrl.oldBank] <= gpr[SP_IDX];
        lrShadow[ctrl.oldBank] <= gpr[LR_IDX];
        stShadow[ctrl.oldBank] <= spsrLive;
        gpr[SP_IDX]            <= spShadow[ctrl.newBank];
        gpr[LR_IDX]            <= lrShadow[ctrl.newBank];
        spsrLive               <= stShadow[ctrl.newBank];
      end
      if (ctrl.swapHigh) begin
        for (int k = 0; k < HI_COUNT; k++) begin
          hiShadow[ctrl.oldHiSide][k] <= gpr[HI_FIRST+k];
          gpr[HI_FIRST+k]             <= hiShadow[ctrl.newHiSide][k];
        end
      end
      // Later assignments win: a same-cycle write lands in the incoming copy.
      if (wrEn)     gpr[wrAddr] <= wrData;
      if (spsrWrEn) spsrLive    <= spsrWrData;
    end
  end

  assign rdDataA = gpr[rdAddrA];
  assign rdDataB = gpr[rdAddrB];
  assign spsrOut = spsrLive;
endmodule

// File: rtl/bankedRegFile.sv
module bankedRegFile
  import bank_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int NUM_REGS = 16,
  localparam int ADDR_W  = $clog2(NUM_REGS)
)(
  input  logic              clk,
  input  logic              rstN,
  input  logic              modeChg,
  input  logic [4:0]        modeReq,
  output logic [4:0]        curMode,
  input  logic [ADDR_W-1:0] rdAddrA,
  output logic [DATA_W-1:0] rdDataA,
  input  logic [ADDR_W-1:0] rdAddrB,
  output logic [DATA_W-1:0] rdDataB,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic              spsrWrEn,
  input  logic [DATA_W-1:0] spsrWrData,
  output logic [DATA_W-1:0] spsrOut
);
  swapCtrl_t ctrl;

  bankCtrl uCtrl (
    .clk(clk), .rstN(rstN), .modeChg(modeChg), .modeReq(modeReq),
    .curMode(curMode), .ctrl(ctrl)
  );

  bankData #(.DATA_W(DATA_W), .NUM_REGS(NUM_REGS)) uData (
    .clk(clk), .rstN(rstN), .ctrl(ctrl),
    .rdAddrA(rdAddrA), .rdDataA(rdDataA),
    .rdAddrB(rdAddrB), .rdDataB(rdDataB),
    .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .spsrWrEn(spsrWrEn), .spsrWrData(spsrWrData), .spsrOut(spsrOut)
  );
endmodule

// File: rtl/bankedRegFileChecker.sv
module bankedRegFileChecker #(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 4
)(
  input logic              clk,
  input logic              rstN,
  input logic              modeChg,
  input logic [4:0]        modeReq,
  input logic [4:0]        curMode,
  input logic [ADDR_W-1:0] rdAddrA,
  input logic [DATA_W-1:0] rdDataA,
  input logic              wrEn,
  input logic [ADDR_W-1:0] wrAddr,
  input logic [DATA_W-1:0] wrData,
  input logic              spsrWrEn,
  input logic [DATA_W-1:0] spsrWrData,
  input logic [DATA_W-1:0] spsrOut
);
  function automatic logic unbanked(input logic [4:0] m);
    return !(m == 5'b10001 || m == 5'b10010 || m == 5'b10011 ||
             m == 5'b10111 || m == 5'b11011);
  endfunction

  AST_RESET_STATE: assert property (@(posedge clk)
    !rstN |=> (curMode == 5'b11111 && spsrOut == '0)); // R1

  AST_MODE_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    modeChg |=> curMode == $past(modeReq)); // R2

  AST_SAME_MODE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (modeChg && modeReq == curMode && !spsrWrEn) |=> $stable(spsrOut)); // R3

  AST_UNBANKED_KEEP: assert property (@(posedge clk) disable iff (!rstN)
    (modeChg && unbanked(modeReq) && unbanked(curMode) && !spsrWrEn)
      |=> $stable(spsrOut)); // R4

  AST_SPSR_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    spsrWrEn |=> spsrOut == $past(spsrWrData)); // R9

  AST_WRITE_VISIBLE: assert property (@(posedge clk) disable iff (!rstN)
    wrEn |=> (rdAddrA != $past(wrAddr) || rdDataA == $past(wrData))); // R10
endmodule

bind bankedRegFile bankedRegFileChecker #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) uChk (
  .clk(clk), .rstN(rstN), .modeChg(modeChg), .modeReq(modeReq), .curMode(curMode),
  .rdAddrA(rdAddrA), .rdDataA(rdDataA), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
  .spsrWrEn(spsrWrEn), .spsrWrData(spsrWrData), .spsrOut(spsrOut)
);

// File: tb/tb_bankedRegFile.sv
`timescale 1ns/1ps
module tb_bankedRegFile;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        modeChg = 1'b0;
  logic [4:0]  modeReq = 5'b0;
  logic [4:0]  curMode;
  logic [3:0]  rdAddrA = 4'd0, rdAddrB = 4'd0, wrAddr = 4'd0;
  logic [31:0] rdDataA, rdDataB, wrData = 32'd0, spsrWrData = 32'd0, spsrOut;
  logic        wrEn = 1'b0, spsrWrEn = 1'b0;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  bankedRegFile dut (
    .clk(clk), .rstN(rstN), .modeChg(modeChg), .modeReq(modeReq), .curMode(curMode),
    .rdAddrA(rdAddrA), .rdDataA(rdDataA), .rdAddrB(rdAddrB), .rdDataB(rdDataB),
    .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .spsrWrEn(spsrWrEn), .spsrWrData(spsrWrData), .spsrOut(spsrOut)
  );

  // Reference model
  logic [31:0] mReg[16];
  logic [31:0] mSp[6], mLr[6], mSt[6];
  logic [31:0] mHi[2][5];
  logic [31:0] mSpsr;
  logic [4:0]  mMode;

  function automatic int bankOf(input logic [4:0] m);
    case (m)
      5'b10001: return 1;
      5'b10010: return 2;
      5'b10011: return 3;
      5'b10111: return 4;
      5'b11011: return 5;
      default:  return 0;
    endcase
  endfunction

  function automatic logic [4:0] pickMode(input int idx);
    case (idx)
      0: return 5'b10000;
      1: return 5'b10001;
      2: return 5'b10010;
      3: return 5'b10011;
      4: return 5'b10111;
      5: return 5'b11011;
      6: return 5'b11111;
      default: return 5'b00000;
    endcase
  endfunction

  task automatic modelReset();
    for (int i = 0; i < 16; i++) mReg[i] = 0;
    for (int b = 0; b < 6; b++) begin mSp[b] = 0; mLr[b] = 0; mSt[b] = 0; end
    for (int s = 0; s < 2; s++) for (int k = 0; k < 5; k++) mHi[s][k] = 0;
    mSpsr = 0;
    mMode = 5'b11111;
  endtask

  task automatic modelStep(input bit chg, input logic [4:0] req, input bit we,
                           input logic [3:0] wa, input logic [31:0] wd,
                           input bit se, input logic [31:0] sd);
    if (chg && req != mMode) begin
      int ob = bankOf(mMode);
      int nb = bankOf(req);
      if (ob != nb) begin
        if (ob == 1 || nb == 1) begin
          int os = (ob == 1) ? 1 : 0;
          for (int k = 0; k < 5; k++) begin
            mHi[os][k] = mReg[8+k];
            mReg[8+k]  = mHi[1-os][k];
          end
        end
        mSp[ob] = mReg[13]; mLr[ob] = mReg[14]; mSt[ob] = mSpsr;
        mReg[13] = mSp[nb]; mReg[14] = mLr[nb]; mSpsr = mSt[nb];
      end
      mMode = req;
    end
    if (we) mReg[wa] = wd;
    if (se) mSpsr = sd;
  endtask

  task automatic check(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // Compare every visible value; call right after a clock edge with strobes idle.
  task automatic compareAll(input string tag);
    for (int i = 0; i < 8; i++) begin
      rdAddrA = 4'(i); rdAddrB = 4'(i + 8);
      #0.1;
      check(tag, $sformatf("reg%0d", i), rdDataA, mReg[i]);
      check(tag, $sformatf("reg%0d", i + 8), rdDataB, mReg[i+8]);
    end
    check(tag, "spsr", spsrOut, mSpsr);
    check(tag, "mode", {27'd0, curMode}, {27'd0, mMode});
  endtask

  task automatic step(input string tag, input bit chg, input logic [4:0] req,
                      input bit we, input logic [3:0] wa, input logic [31:0] wd,
                      input bit se, input logic [31:0] sd);
    @(negedge clk);
    modeChg = chg; modeReq = req; wrEn = we; wrAddr = wa; wrData = wd;
    spsrWrEn = se; spsrWrData = sd;
    @(posedge clk);
    modelStep(chg, req, we, wa, wd, se, sd);
    #0.3;
    modeChg = 0; wrEn = 0; spsrWrEn = 0;
    compareAll(tag);
  endtask

  task automatic fillRegs(input string tag, input logic [31:0] base);
    for (int i = 0; i < 16; i++)
      step(tag, 0, 5'b0, 1, 4'(i), base + 32'(i), 0, 0);
    step(tag, 0, 5'b0, 0, 4'd0, 0, 1, base ^ 32'hFFFF_0000);
  endtask

  initial begin
    #150000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int seedSink;
    seedSink = $urandom(32'd1234);
    modelReset();
    repeat (3) @(posedge clk);
    #0.3;
    compareAll("R1");
    rstN = 1'b1;

    // R1: shadows are clear after reset; entering fast-interrupt restores zeros
    fillRegs("R10", 32'h1000_0000);
    step("R1 R6", 1, 5'b10001, 0, 0, 0, 0, 0);
    // R3: same-mode request changes nothing
    fillRegs("R10", 32'h2000_0000);
    step("R3", 1, 5'b10001, 0, 0, 0, 0, 0);
    // R5 R6 R7: round trip user -> fast-int -> int -> user
    step("R2", 1, 5'b10000, 0, 0, 0, 0, 0);
    fillRegs("R10", 32'h3000_0000);
    step("R6", 1, 5'b10001, 0, 0, 0, 0, 0);
    fillRegs("R10", 32'h4000_0000);
    step("R6 R5", 1, 5'b10010, 0, 0, 0, 0, 0);
    fillRegs("R10", 32'h5000_0000);
    step("R7 R5 R8", 1, 5'b10000, 0, 0, 0, 0, 0);
    // R4: user <-> system and an unrecognised code share the common bank
    step("R4", 1, 5'b11111, 0, 0, 0, 0, 0);
    step("R4 R2", 1, 5'b00000, 0, 0, 0, 0, 0);
    step("R4", 1, 5'b10000, 0, 0, 0, 0, 0);
    // R9: same-cycle write during a bank change goes to the new copy
    step("R9", 1, 5'b10011, 1, 4'd13, 32'hCAFE_0013, 1, 32'h0000_00D3);
    step("R9", 1, 5'b10000, 1, 4'd9, 32'hBEEF_0009, 0, 0);
    step("R9 R5", 1, 5'b10011, 0, 0, 0, 0, 0);
    step("R9", 1, 5'b10001, 1, 4'd10, 32'h0F1F_0010, 0, 0);
    step("R9 R6", 1, 5'b10000, 0, 0, 0, 0, 0);
    step("R9 R6", 1, 5'b10001, 0, 0, 0, 0, 0);
    step("R2", 1, 5'b11011, 0, 0, 0, 0, 0);

    // Random mix
    for (int n = 0; n < 1500; n++) begin
      bit chg = ($urandom_range(0, 2) == 0);
      logic [4:0] req = pickMode($urandom_range(0, 7));
      bit we = ($urandom_range(0, 1) == 1);
      logic [3:0] wa = 4'($urandom_range(0, 15));
      bit se = ($urandom_range(0, 4) == 0);
      step("R5 R6 R7 R8 R9", chg, req, we, wa, $urandom, se, $urandom);
    end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule